// File: doc/BRIEF.md
# Embedded Logic Analyzer Capture Core

This block is an in-system capture engine that sits inside a larger chip. On every rising edge of the design clock it records a wide probe bus into an on-chip circular buffer. At the same time it compares a separate trigger bus against a programmable pattern under a per-bit mask. The trigger can be set to fire only on the Nth qualifying match. A programmable number of samples taken before the trigger is kept. Once the window that surrounds the trigger is complete, the buffer is frozen so a host can read it back at leisure.

A host programs the core through a small write-only register port. Register 0 is the control register, where bit 0 = 1 arms the core. Register 1 holds the pattern, register 2 the mask, register 3 the repeat count and register 4 the pre-trigger depth. The host watches a 3-bit status output. It then pulls the captured words out oldest first, using a start strobe and an advance strobe. Because sampling is synchronous, clock waveforms themselves cannot be observed. The buffer depth must be a power of two.

Top module: `probe_capture`

## Requirements
- R1: After reset the status output is 3'b000 (bit 0 armed, bit 1 triggered, bit 2 done).
- R2: A write to register 0 with data bit 0 = 1 restarts capture. On the next cycle the status is armed = 1, triggered = 0, done = 0.
- R3: A trigger sample matches when ((trigData XOR pattern) AND mask) is zero. A mask bit of 0 makes that trigger bit a don't-care.
- R4: Only the Nth eligible match fires the trigger, where N is the value in register 3. A value of 0 or 1 fires on the first match. Non-matching samples between matches do not reset the count.
- R5: The samples written after arming are numbered k = 1, 2, and so on. Sample k can count as a match only if k is greater than the pre-trigger depth P, which is register 4 taken modulo DEPTH. Matches at k <= P are ignored.
- R6: The captured window holds DEPTH consecutive samples: the P samples before the trigger sample, the trigger sample itself, and DEPTH-P-1 samples after it.
- R7: Once done is set, the buffer and status no longer change, whatever the probe and trigger inputs do, until the core is re-armed.
- R8: Triggered rises in the cycle after the firing sample and stays set. Done rises after the last sample of the window is written. At that point armed falls. With P = DEPTH-1, done rises together with triggered.
- R9: A pulse on rdStart presents the oldest sample of the window on rdData one cycle later. Each cycle with rdNext high advances to the next newer sample. Reading continues past the newest sample and wraps back to the oldest.
- R10: Re-arming while a capture is in progress, including after the trigger has fired, abandons that capture. A new capture then starts from an empty buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Design clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| probeData | input | DATA_W | Probe bus recorded each cycle while capturing |
| trigData | input | TRIG_W | Bus compared against the trigger pattern |
| cfgWrEn | input | 1 | Host register write strobe |
| cfgAddr | input | 3 | Host register index (0 control, 1 pattern, 2 mask, 3 repeat, 4 pre-trigger) |
| cfgWrData | input | 32 | Host write data |
| rdStart | input | 1 | Load the read pointer with the oldest window sample |
| rdNext | input | 1 | Advance the read pointer by one, wrapping |
| rdData | output | DATA_W | Sample at the read pointer, one cycle latency |
| status | output | 3 | {done, triggered, armed} |

## Verification
Two events can land on the same clock edge: a re-arm write and a trigger firing or capture completing. Firing and the window closing also coincide when the pre-trigger depth is DEPTH-1. The bench re-arms while the post-trigger phase is running and checks that the status drops back to armed-only. It then checks that the readback is built around the new trigger sample rather than the old one. It also sets P = DEPTH-1 and checks that triggered and done appear in the same cycle, with the trigger sample read back last.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_WAIT,
    ST_POST,
    ST_DONE
  } capState_t;

  typedef struct packed {
    logic clearPtr;
    logic wrEn;
    logic latchTrig;
  } capStrobe_t;

  localparam logic [2:0] REG_CTRL    = 3'd0;
  localparam logic [2:0] REG_PATTERN = 3'd1;
  localparam logic [2:0] REG_MASK    = 3'd2;
  localparam logic [2:0] REG_REPEAT  = 3'd3;
  localparam logic [2:0] REG_PRE     = 3'd4;
endpackage

// File: rtl/capture_ctrl.sv
module capture_ctrl
  import cap_pkg::*;
#(
  parameter int TRIG_W = 8,
  parameter int REP_W  = 8,
  parameter int AW     = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [2:0]        cfgAddr,
  input  logic [31:0]       cfgWrData,
  input  logic              trigHit,
  output capStrobe_t        strb,
  output logic [TRIG_W-1:0] pattern,
  output logic [TRIG_W-1:0] mask,
  output logic [AW-1:0]     preCount,
  output logic [2:0]        status
);
  capState_t        state;
  logic [AW-1:0]    fillCnt;
  logic [AW-1:0]    postLeft;
  logic [REP_W-1:0] matchCnt;
  logic [REP_W-1:0] repeatCnt;
  logic [REP_W-1:0] repEff;
  logic [REP_W:0]   hitNum;
  logic [AW:0]      fillNext;
  logic [AW-1:0]    postInit;
  logic             armReq;
  logic             fire;
  logic             capturing;
  logic             unusedCfg;

  assign unusedCfg = ^cfgWrData;
  assign armReq    = cfgWrEn && (cfgAddr == REG_CTRL) && cfgWrData[0];
  assign repEff    = (repeatCnt == '0) ? REP_W'(1) : repeatCnt;
  assign hitNum    = {1'b0, matchCnt} + (REP_W+1)'(1);
  assign fire      = hitNum >= {1'b0, repEff};
  assign fillNext  = {1'b0, fillCnt} + (AW+1)'(1);
  assign postInit  = ~preCount;
  assign capturing = (state == ST_FILL) || (state == ST_WAIT) || (state == ST_POST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pattern   <= '0;
      mask      <= '0;
      repeatCnt <= REP_W'(1);
      preCount  <= '0;
    end else if (cfgWrEn) begin
      case (cfgAddr)
        REG_PATTERN: pattern   <= cfgWrData[TRIG_W-1:0];
        REG_MASK:    mask      <= cfgWrData[TRIG_W-1:0];
        REG_REPEAT:  repeatCnt <= cfgWrData[REP_W-1:0];
        REG_PRE:     preCount  <= cfgWrData[AW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      fillCnt  <= '0;
      matchCnt <= '0;
      postLeft <= '0;
    end else if (armReq) begin
      state    <= (preCount == '0) ? ST_WAIT : ST_FILL;
      fillCnt  <= '0;
      matchCnt <= '0;
      postLeft <= '0;
    end else begin
      case (state)
        ST_FILL: begin
          fillCnt <= fillNext[AW-1:0];
          if (fillNext == {1'b0, preCount}) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (trigHit) begin
            if (fire) begin
              postLeft <= postInit;
              state    <= (postInit == '0) ? ST_DONE : ST_POST;
            end else begin
              matchCnt <= hitNum[REP_W-1:0];
            end
          end
        end
        ST_POST: begin
          postLeft <= postLeft - AW'(1);
          if (postLeft == AW'(1)) state <= ST_DONE;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    strb.clearPtr  = armReq;
    strb.wrEn      = !armReq && capturing;
    strb.latchTrig = !armReq && (state == ST_WAIT) && trigHit && fire;
  end

  assign status = {state == ST_DONE,
                   (state == ST_POST) || (state == ST_DONE),
                   capturing};
endmodule

// File: rtl/capture_data.sv
module capture_data
  import cap_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TRIG_W = 8,
  parameter int DEPTH  = 32,
  parameter int AW     = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  capStrobe_t        strb,
  input  logic [DATA_W-1:0] probeData,
  input  logic [TRIG_W-1:0] trigData,
  input  logic [TRIG_W-1:0] pattern,
  input  logic [TRIG_W-1:0] mask,
  input  logic [AW-1:0]     preCount,
  input  logic              rdStart,
  input  logic              rdNext,
  output logic              trigHit,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wrPtr;
  logic [AW-1:0]     trigAddr;
  logic [AW-1:0]     rdPtr;
  logic [AW-1:0]     rdPtrNext;
  logic [AW-1:0]     oldest;

  assign trigHit = ((trigData ^ pattern) & mask) == '0;
  assign oldest  = trigAddr - preCount;

  always_comb begin
    if (rdStart)     rdPtrNext = oldest;
    else if (rdNext) rdPtrNext = rdPtr + AW'(1);
    else             rdPtrNext = rdPtr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      trigAddr <= '0;
      rdPtr    <= '0;
    end else begin
      rdPtr <= rdPtrNext;
      if (strb.clearPtr)  wrPtr <= '0;
      else if (strb.wrEn) wrPtr <= wrPtr + AW'(1);
      if (strb.latchTrig) trigAddr <= wrPtr;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.wrEn) mem[wrPtr] <= probeData;
    rdData <= mem[rdPtrNext];
  end
endmodule

// File: rtl/probe_capture.sv
module probe_capture
  import cap_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TRIG_W = 8,
  parameter int DEPTH  = 32,
  parameter int REP_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] probeData,
  input  logic [TRIG_W-1:0] trigData,
  input  logic              cfgWrEn,
  input  logic [2:0]        cfgAddr,
  input  logic [31:0]       cfgWrData,
  input  logic              rdStart,
  input  logic              rdNext,
  output logic [DATA_W-1:0] rdData,
  output logic [2:0]        status
);
  localparam int AW = $clog2(DEPTH);

  capStrobe_t        strb;
  logic              trigHit;
  logic [TRIG_W-1:0] pattern;
  logic [TRIG_W-1:0] mask;
  logic [AW-1:0]     preCount;

  capture_ctrl #(.TRIG_W(TRIG_W), .REP_W(REP_W), .AW(AW)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .trigHit(trigHit), .strb(strb),
    .pattern(pattern), .mask(mask), .preCount(preCount), .status(status)
  );

  capture_data #(.DATA_W(DATA_W), .TRIG_W(TRIG_W), .DEPTH(DEPTH), .AW(AW)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .probeData(probeData),
    .trigData(trigData), .pattern(pattern), .mask(mask), .preCount(preCount),
    .rdStart(rdStart), .rdNext(rdNext), .trigHit(trigHit), .rdData(rdData)
  );
endmodule

// File: rtl/probe_capture_chk.sv
module probe_capture_chk
  import cap_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       cfgWrEn,
  input logic [2:0] cfgAddr,
  input logic       armBit,
  input logic [2:0] status,
  input logic       trigHit
);
  logic armReq;
  assign armReq = cfgWrEn && (cfgAddr == REG_CTRL) && armBit;

  a_r8_done_not_armed: assert property (@(posedge clk) disable iff (!rstN)
    status[2] |-> (status[1] && !status[0]));

  a_r7_done_holds: assert property (@(posedge clk) disable iff (!rstN)
    (status[2] && !armReq) |=> status[2]);

  a_r2_arm_restarts: assert property (@(posedge clk) disable iff (!rstN)
    armReq |=> (status == 3'b001));

  a_r4_trigger_from_hit: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[1]) |-> $past(trigHit));

  a_r10_rearm_clears_trig: assert property (@(posedge clk) disable iff (!rstN)
    (status[1] && armReq) |=> !status[1]);
endmodule

bind probe_capture probe_capture_chk uChk (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
  .armBit(cfgWrData[0]), .status(status), .trigHit(trigHit)
);

// File: tb/probe_capture_test.sv
`timescale 1ns/1ps
module probe_capture_test;
  localparam int DATA_W = 16;
  localparam int TRIG_W = 8;
  localparam int DEPTH  = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [DATA_W-1:0] probeData = '0;
  logic [TRIG_W-1:0] trigData = '0;
  logic              cfgWrEn = 1'b0;
  logic [2:0]        cfgAddr = '0;
  logic [31:0]       cfgWrData = '0;
  logic              rdStart = 1'b0;
  logic              rdNext = 1'b0;
  logic [DATA_W-1:0] rdData;
  logic [2:0]        status;

  int checks = 0;
  int fails  = 0;
  logic [DATA_W-1:0] trigVal;

  always #5 clk = ~clk;

  probe_capture #(.DATA_W(DATA_W), .TRIG_W(TRIG_W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .probeData(probeData), .trigData(trigData),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .rdStart(rdStart), .rdNext(rdNext), .rdData(rdData), .status(status)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic [TRIG_W-1:0] t);
    @(negedge clk);
    cfgWrEn   = 1'b0;
    trigData  = t;
    probeData = probeData + 1'b1;
  endtask

  task automatic cfgWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWrEn   = 1'b1;
    cfgAddr   = a;
    cfgWrData = d;
    trigData  = '0;
    probeData = probeData + 1'b1;
  endtask

  task automatic setup(input int pat, input int msk, input int rep, input int pre);
    cfgWrite(3'd1, pat);
    cfgWrite(3'd2, msk);
    cfgWrite(3'd3, rep);
    cfgWrite(3'd4, pre);
    cfgWrite(3'd0, 32'd1);
  endtask

  task automatic waitDone(input string req);
    for (int i = 0; i < 200; i++) begin
      tick('0);
      if (status[2]) break;
    end
    check(req, status, 3'b110);
  endtask

  task automatic readCheck(input string req, input logic [DATA_W-1:0] t, input int pre);
    int bad = 0;
    logic [DATA_W-1:0] exp;
    logic [DATA_W-1:0] firstSeen = '0;
    @(negedge clk);
    rdStart = 1'b1;
    @(negedge clk);
    rdStart = 1'b0;
    rdNext  = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      exp = t - DATA_W'(pre) + DATA_W'(i);
      if (i == 0) firstSeen = rdData;
      if (rdData !== exp && bad == 0) begin
        $display("FAIL %s word %0d actual=%0h expected=%0h", req, i, rdData, exp);
        bad = 1;
      end
      @(negedge clk);
    end
    checks++;
    if (bad != 0) fails++;
    check("R9 readback wraps to oldest", rdData, firstSeen);
    rdNext = 1'b0;
  endtask

  task automatic testReset();
    check("R1 reset status", status, 3'b000);
  endtask

  task automatic testBasic();
    setup(8'hA5, 8'hFF, 1, 4);
    tick('0);
    check("R2 armed after arm write", status, 3'b001);
    for (int k = 2; k <= 10; k++) tick('0);
    tick(8'hA5);
    trigVal = probeData;
    check("R3 no trigger before match", status[1], 1'b0);
    tick('0);
    check("R8 triggered after firing sample", status, 3'b011);
    waitDone("R8 done after window");
    readCheck("R6 window pre=4", trigVal, 4);
  endtask

  task automatic testMask();
    setup(8'h30, 8'hF0, 1, 0);
    tick(8'h4C);
    tick(8'h3C);
    trigVal = probeData;
    check("R3 masked mismatch ignored", status[1], 1'b0);
    tick('0);
    check("R3 masked match fires", status[1], 1'b1);
    waitDone("R8 done mask case");
    readCheck("R6 window pre=0", trigVal, 0);
  endtask

  task automatic testRepeat();
    setup(8'h11, 8'hFF, 3, 0);
    tick(8'h11);
    tick('0);
    tick(8'h11);
    tick('0);
    tick(8'h11);
    trigVal = probeData;
    check("R4 no fire before third match", status[1], 1'b0);
    tick('0);
    check("R4 third match fires", status[1], 1'b1);
    waitDone("R8 done repeat case");
    readCheck("R4 window on third match", trigVal, 0);
  endtask

  task automatic testHoldoff();
    setup(8'h5A, 8'hFF, 1, 8);
    for (int k = 1; k <= 8; k++) tick((k == 8) ? 8'h5A : 8'h00);
    tick(8'h5A);
    trigVal = probeData;
    check("R5 match at k=P ignored", status, 3'b001);
    tick('0);
    check("R5 match at k=P+1 fires", status[1], 1'b1);
    waitDone("R8 done holdoff case");
    readCheck("R5 window pre=8", trigVal, 8);
  endtask

  task automatic testFreeze();
    for (int i = 0; i < 12; i++) tick(8'h5A);
    check("R7 status frozen", status, 3'b110);
    readCheck("R7 buffer frozen", trigVal, 8);
  endtask

  task automatic testRearm();
    setup(8'h77, 8'hFF, 1, 2);
    tick('0);
    tick('0);
    tick('0);
    tick(8'h77);
    tick('0);
    tick('0);
    check("R10 in post phase", status, 3'b011);
    cfgWrite(3'd0, 32'd1);
    tick('0);
    check("R10 rearm clears triggered", status, 3'b001);
    tick('0);
    tick(8'h77);
    trigVal = probeData;
    tick('0);
    check("R10 new trigger fires", status[1], 1'b1);
    waitDone("R10 done after rearm");
    readCheck("R10 window from new trigger", trigVal, 2);
  endtask

  task automatic testFullPre();
    setup(8'h99, 8'hFF, 1, DEPTH - 1);
    for (int k = 1; k < DEPTH; k++) tick('0);
    tick(8'h99);
    trigVal = probeData;
    check("R5 not yet fired at k=DEPTH", status, 3'b001);
    tick('0);
    check("R8 done with trigger at P=DEPTH-1", status, 3'b110);
    readCheck("R6 window pre=DEPTH-1", trigVal, DEPTH - 1);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    tick('0);
    testReset();
    testBasic();
    testMask();
    testRepeat();
    testHoldoff();
    testFreeze();
    testRearm();
    testFullPre();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule